// File: doc/BRIEF.md
# Amplitude-Keyed IR Carrier Generator and Period Qualifier

This block sits between a serial transmit/receive path and an infrared front end that uses amplitude keying. On the transmit side, while `tx_data` is active it produces a square-wave LED drive whose frequency comes from a divider value `md_div`. When `tx_data` is idle the LED is dark.

On the receive side it re-times the raw detector output `rx_pulse`. It measures the number of tick cycles between successive timed transitions and raises `carrier_det` once two back-to-back periods fall inside an acceptance window. The same divider value that sets the transmit carrier also centres that window. A separate value `rats_win` widens it. The `enpos` control picks between timing rising transitions only and timing both transitions against half-size bounds.

One clock `clk` drives everything. It is taken as the 7.3728 MHz tick, about 135 ns, and one carrier-clock cycle at 3.6864 MHz equals two ticks. Reset is synchronous and active high.

Top module: `ask_ir_core`

## Requirements
- R1: While `rst` is 1 at a clock edge, `led_out` and `carrier_det` are both 0 after that edge, whatever `tx_data` and `rx_pulse` do.
- R2: After any clock edge at which `tx_data` is 0, `led_out` is 0.
- R3: When `tx_data` is first sampled 1 at edge k, `led_out` starts a periodic waveform after edge k. Its period is 2·(`md_div`+2) ticks, and it repeats for as long as `tx_data` stays 1.
- R4: Within each carrier period, `led_out` is 1 for the first 2·floor((`md_div`+2)/2) ticks and 0 for the rest. For odd `md_div` this rounds the high phase down.
- R5: With `enpos`=1, a measured period p, in ticks between two timed transitions, qualifies when lo ≤ p ≤ hi, both bounds inclusive. Here lo = 2·`md_div`+3+`rats_win` and hi = 2·`md_div`+3+6·(`rats_win`+1).
- R6: With `enpos`=1, only rising transitions of `rx_pulse` are timed. Falling transitions do not restart the measurement and do not change `carrier_det`.
- R7: With `enpos`=0, both rising and falling transitions are timed. Each interval is compared against floor(lo/2) and floor(hi/2).
- R8: `rx_pulse` passes through two synchroniser flops. Let a transition first be sampled at edge k. If it closes the second consecutive qualifying period, `carrier_det` is 1 after edge k+2. The first timed transition after reset only starts a measurement.
- R9: A timed transition that closes a non-qualifying period drives `carrier_det` to 0 after edge k+2 and restarts the count. Two further qualifying periods are then needed.
- R10: If no timed transition follows the one sampled at edge k, `carrier_det` (when 1) stays 1 after edge k+hi+2 and is 0 after edge k+hi+3. Here hi is the active upper bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, nominally 7.3728 MHz |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 1 | Transmit data; 1 keys the carrier on |
| rx_pulse | input | 1 | Raw, unsynchronised detector output |
| md_div | input | MD_W (8) | Divider value for carrier and window centre |
| rats_win | input | RATS_W (4) | Window widening value |
| enpos | input | 1 | 1: time rising transitions only; 0: time both with halved bounds |
| led_out | output | 1 | LED drive |
| carrier_det | output | 1 | Carrier present on receive |

## Verification
A phase counter that slips or wraps one tick early shows at `led_out` within a single carrier period. It appears as a high phase or period that is off by one against the expected pattern. Wrong bound arithmetic or edge selection shows up three cycles after the transition that closes the second qualifying period. Streak state that is not cleared shows up as a `carrier_det` that stays high after a short period, or after the hi-plus-three-cycle timeout. The bench therefore compares `led_out` on every cycle of each burst. It compares `carrier_det` exactly at each transition's response cycle and at both sides of the timeout edge.

// File: rtl/ask_ir_pkg.sv
package ask_ir_pkg;

    localparam int MD_W_DEF   = 8;
    localparam int RATS_W_DEF = 4;

    // Progress toward a detected carrier
    typedef enum logic [1:0] {
        STREAK_NONE = 2'd0,
        STREAK_ONE  = 2'd1,
        STREAK_FULL = 2'd2
    } streak_e;

    // Transition strobes from the receive synchroniser
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic int hi_bound_max(input int md_w, input int rats_w);
        return 2 * ((1 << md_w) - 1) + 3 + 6 * (1 << rats_w);
    endfunction

    // Span counter width: room for the largest bound plus saturation headroom
    function automatic int span_width(input int md_w, input int rats_w);
        return $clog2(hi_bound_max(md_w, rats_w) + 2);
    endfunction

endpackage

// File: rtl/ask_rx_sync.sv
module ask_rx_sync
    import ask_ir_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_raw,
    output edge_pair_t edges
);

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   seen_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= SYNC_STAGES'(rx_raw);
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[SYNC_STAGES-2:0], rx_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= stage_q[SYNC_STAGES-1];
    end

    assign edges.rise = stage_q[SYNC_STAGES-1] & ~seen_q;
    assign edges.fall = ~stage_q[SYNC_STAGES-1] & seen_q;

endmodule

// File: rtl/ask_win_bounds.sv
module ask_win_bounds #(
    parameter int MD_W   = 8,
    parameter int RATS_W = 4,
    parameter int CNT_W  = 10
) (
    input  logic [MD_W-1:0]   md_div,
    input  logic [RATS_W-1:0] rats_win,
    input  logic              enpos,
    output logic [CNT_W-1:0]  lo_bound,
    output logic [CNT_W-1:0]  hi_bound
);

    logic [CNT_W-1:0] base_w;
    logic [CNT_W-1:0] rats_x;
    logic [CNT_W-1:0] lo_full;
    logic [CNT_W-1:0] hi_full;

    always_comb begin
        rats_x  = CNT_W'(rats_win);
        base_w  = (CNT_W'(md_div) << 1) + CNT_W'(3);
        lo_full = base_w + rats_x;
        hi_full = base_w + (rats_x + CNT_W'(1)) * CNT_W'(6);
        if (enpos) begin
            lo_bound = lo_full;
            hi_bound = hi_full;
        end else begin
            // both transitions timed: each interval is half a period
            lo_bound = lo_full >> 1;
            hi_bound = hi_full >> 1;
        end
    end

endmodule

// File: rtl/ask_period_meter.sv
module ask_period_meter
    import ask_ir_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timed_edge,
    input  logic [CNT_W-1:0] lo_bound,
    input  logic [CNT_W-1:0] hi_bound,
    output logic [CNT_W-1:0] span,
    output logic             win_hit,
    output logic             carrier_det
);

    localparam logic [CNT_W-1:0] SPAN_SAT = '1;

    logic [CNT_W-1:0] span_q;
    streak_e          streak_q;
    logic             det_q;
    logic             expired;

    assign win_hit = (span_q >= lo_bound) && (span_q <= hi_bound);
    assign expired = span_q > hi_bound;

    always_ff @(posedge clk) begin
        if (rst) begin
            // saturated span makes the first transition a reference only
            span_q   <= SPAN_SAT;
            streak_q <= STREAK_NONE;
            det_q    <= 1'b0;
        end else begin
            if (timed_edge)              span_q <= CNT_W'(1);
            else if (span_q != SPAN_SAT) span_q <= span_q + CNT_W'(1);

            if (timed_edge) begin
                if (win_hit) begin
                    streak_q <= (streak_q == STREAK_NONE) ? STREAK_ONE : STREAK_FULL;
                    det_q    <= (streak_q != STREAK_NONE);
                end else begin
                    streak_q <= STREAK_NONE;
                    det_q    <= 1'b0;
                end
            end else if (expired) begin
                streak_q <= STREAK_NONE;
                det_q    <= 1'b0;
            end
        end
    end

    assign span        = span_q;
    assign carrier_det = det_q;

endmodule

// File: rtl/ask_carrier_gen.sv
module ask_carrier_gen #(
    parameter int MD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_data,
    input  logic [MD_W-1:0] md_div,
    output logic            led_out
);

    localparam int PH_W = MD_W + 2;

    logic [PH_W-1:0] half_len;
    logic [PH_W-1:0] period_len;
    logic [PH_W-1:0] high_len;
    logic [PH_W-1:0] ph_q;
    logic            tx_q;

    always_comb begin
        half_len   = PH_W'(md_div) + PH_W'(2);
        period_len = half_len << 1;
        high_len   = {half_len[PH_W-1:1], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
            ph_q <= '0;
        end else begin
            tx_q <= tx_data;
            if (!tx_q)                                ph_q <= '0;
            else if (ph_q >= period_len - PH_W'(1))   ph_q <= '0;
            else                                      ph_q <= ph_q + PH_W'(1);
        end
    end

    assign led_out = tx_q && (ph_q < high_len);

endmodule

// File: rtl/ask_ir_core.sv
module ask_ir_core
    import ask_ir_pkg::*;
#(
    parameter int MD_W        = MD_W_DEF,
    parameter int RATS_W      = RATS_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_data,
    input  logic              rx_pulse,
    input  logic [MD_W-1:0]   md_div,
    input  logic [RATS_W-1:0] rats_win,
    input  logic              enpos,
    output logic              led_out,
    output logic              carrier_det
);

    localparam int CNT_W = span_width(MD_W, RATS_W);

    edge_pair_t       rx_edges;
    logic             timed_edge;
    logic [CNT_W-1:0] lo_bound;
    logic [CNT_W-1:0] hi_bound;
    logic [CNT_W-1:0] span;
    logic             win_hit;

    ask_carrier_gen #(.MD_W(MD_W)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .tx_data (tx_data),
        .md_div  (md_div),
        .led_out (led_out)
    );

    ask_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rx_raw (rx_pulse),
        .edges  (rx_edges)
    );

    assign timed_edge = rx_edges.rise | (~enpos & rx_edges.fall);

    ask_win_bounds #(.MD_W(MD_W), .RATS_W(RATS_W), .CNT_W(CNT_W)) u_bounds (
        .md_div   (md_div),
        .rats_win (rats_win),
        .enpos    (enpos),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound)
    );

    ask_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .timed_edge  (timed_edge),
        .lo_bound    (lo_bound),
        .hi_bound    (hi_bound),
        .span        (span),
        .win_hit     (win_hit),
        .carrier_det (carrier_det)
    );

endmodule

// File: rtl/ask_ir_core_chk.sv
module ask_ir_core_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_data,
    input logic             led_out,
    input logic             carrier_det,
    input logic             timed_edge,
    input logic             win_hit,
    input logic [CNT_W-1:0] span,
    input logic [CNT_W-1:0] hi_bound
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!led_out && !carrier_det));

    // R2
    idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_data |=> !led_out);

    // R3
    led_keyed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(led_out) |-> $past(tx_data));

    // R8
    det_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_det) |-> $past(timed_edge && win_hit));

    // R9
    bad_period_chk: assert property (@(posedge clk) disable iff (rst)
        (timed_edge && !win_hit) |=> !carrier_det);

    // R10
    expire_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!timed_edge && (span > hi_bound)) |=> !carrier_det);

endmodule

bind ask_ir_core ask_ir_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_data     (tx_data),
    .led_out     (led_out),
    .carrier_det (carrier_det),
    .timed_edge  (timed_edge),
    .win_hit     (win_hit),
    .span        (span),
    .hi_bound    (hi_bound)
);

// File: tb/ask_ir_core_bench.sv
`timescale 1ns/1ps
module ask_ir_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_data = 1'b0;
    logic       rx_pulse = 1'b0;
    logic       enpos = 1'b1;
    logic [7:0] md_div = 8'd5;
    logic [3:0] rats_win = 4'd0;
    logic       led_out;
    logic       carrier_det;

    ask_ir_core u_ask_ir_core (
        .clk         (clk),
        .rst         (rst),
        .tx_data     (tx_data),
        .rx_pulse    (rx_pulse),
        .md_div      (md_div),
        .rats_win    (rats_win),
        .enpos       (enpos),
        .led_out     (led_out),
        .carrier_det (carrier_det)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    on_det;
        bit    want;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic push(input int at, input bit on_det, input bit want, input string tag);
        exp_t e;
        e.at = at; e.on_det = on_det; e.want = want; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare every expectation that has come due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            logic got;
            e   = sb_q.pop_front();
            got = e.on_det ? carrier_det : led_out;
            n_chk++;
            if (got !== e.want) begin
                n_fail++;
                $display("FAIL %s cycle %0d %s: actual %0b expected %0b",
                         e.tag, cyc, e.on_det ? "carrier_det" : "led_out", got, e.want);
            end
        end
    end

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_data = 1'b1; rx_pulse = 1'b0;
        push(cyc + 2, 1'b0, 1'b0, "R1");
        push(cyc + 2, 1'b1, 1'b0, "R1");
        repeat (3) @(negedge clk);
        tx_data = 1'b0; rst = 1'b0;
        drain();
    endtask

    task automatic tx_run(input int md, input int len);
        int c, per, hl;
        md_div = 8'(md);
        per = 2 * (md + 2);
        hl  = ((md + 2) / 2) * 2;
        @(negedge clk);
        c = cyc;
        for (int k = 0; k < 4; k++) push(c + 1 + k, 1'b0, 1'b0, "R2");
        repeat (4) @(negedge clk);
        c = cyc;
        tx_data = 1'b1;
        for (int k = 0; k < len; k++)
            push(c + 1 + k, 1'b0, (k % per) < hl, ((k % per) < hl) ? "R4" : "R3");
        for (int k = len; k < len + 5; k++) push(c + 1 + k, 1'b0, 1'b0, "R2");
        repeat (len) @(negedge clk);
        tx_data = 1'b0;
        repeat (7) @(negedge clk);
        drain();
    endtask

    task automatic rx_run(input int md, input int rats, input bit ep, input int pw,
                          input int rises[$], input string tag);
        int  lo, hi, c0, last, end_o, gap;
        int  tms[$];
        bit  in_prev, in_cur, dq;
        md_div = 8'(md); rats_win = 4'(rats); enpos = ep;
        lo = 2 * md + 3 + rats;
        hi = 2 * md + 3 + 6 * (rats + 1);
        if (!ep) begin lo = lo / 2; hi = hi / 2; end
        foreach (rises[i]) begin
            tms.push_back(rises[i]);
            if (!ep) tms.push_back(rises[i] + pw);
        end
        @(negedge clk);
        c0 = cyc;
        in_prev = 1'b0; dq = 1'b0;
        foreach (tms[j]) begin
            in_cur = 1'b0;
            if (j > 0) begin
                gap = tms[j] - tms[j-1];
                in_cur = (gap >= lo) && (gap <= hi);
            end
            dq = in_cur && in_prev;
            push(c0 + tms[j] + 3, 1'b1, dq, tag);
            in_prev = in_cur;
        end
        last  = tms[tms.size()-1];
        end_o = last + hi + 8;
        if (dq) begin
            push(c0 + last + hi + 3, 1'b1, 1'b1, "R10");
            push(c0 + last + hi + 4, 1'b1, 1'b0, "R10");
        end
        for (int o = 0; o <= end_o; o++) begin
            logic lvl;
            lvl = 1'b0;
            foreach (rises[i]) if (o >= rises[i] && o < rises[i] + pw) lvl = 1'b1;
            rx_pulse = lvl;
            @(negedge clk);
        end
        rx_pulse = 1'b0;
        drain();
    endtask

    task automatic rx_periodic(input int md, input int rats, input bit ep, input int pw,
                               input int per, input int n, input string tag);
        int r[$];
        for (int i = 0; i < n; i++) r.push_back(i * per);
        do_reset();
        rx_run(md, rats, ep, pw, r, tag);
    endtask

    initial begin
        int h[$];
        repeat (2) @(negedge clk);
        do_reset();
        // transmit carrier: even, odd and minimum divide values
        tx_run(5, 40);
        tx_run(6, 34);
        tx_run(0, 12);
        tx_run(7, 40);
        // receive window, rising transitions only
        rx_periodic(5, 0, 1'b1, 2, 13, 4, "R8");   // lower bound, detect on third
        rx_periodic(5, 0, 1'b1, 2, 19, 4, "R5");   // upper bound
        rx_periodic(5, 0, 1'b1, 2, 12, 4, "R5");   // one below lower bound
        rx_periodic(5, 0, 1'b1, 2, 20, 4, "R5");   // one above upper bound
        rx_periodic(10, 1, 1'b1, 3, 24, 4, "R5");  // other divide and widening
        rx_periodic(5, 2, 1'b1, 3, 31, 3, "R5");   // widened upper bound
        rx_periodic(5, 0, 1'b1, 2, 14, 4, "R6");   // falling transitions ignored
        // both transitions timed, halved bounds
        rx_periodic(5, 0, 1'b0, 2, 14, 4, "R7");
        rx_periodic(5, 0, 1'b0, 7, 14, 3, "R7");
        rx_periodic(5, 0, 1'b0, 9, 18, 3, "R7");
        rx_periodic(5, 0, 1'b0, 6, 12, 3, "R7");
        // short period inside a good train
        h = '{0, 13, 26, 39, 45, 58, 71};
        do_reset();
        rx_run(5, 0, 1'b1, 2, h, "R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule